// File: doc/BRIEF.md
# Parallel Flash Bus Mode Controller

This block is the control front end of an emulated parallel NOR flash device. It samples the active-low chip enable, output enable, write enable and hardware reset pins on a synchronous clock. It classifies every sample into one bus mode: read, write, output disable, standby or reset. From that mode it drives the enable of an 8-bit data bus, and it presents each recognised write to an external command decoder as a one-cycle pulse that carries the address and the data. The command decoder has no back-pressure, so a write pulse is never stalled or queued.

The block tracks whether an embedded program or erase is running, using start and done strobes from the algorithm engine, and it shows this on a ready/busy output. It picks the byte it returns on a read from three sources: an operation status byte while an operation runs, an internal identification register while autoselect is active, or array data otherwise. A reset pulse on the hardware reset pin is qualified by a minimum width. A qualified pulse aborts the running operation and starts a recovery period. This period is longer when an operation was interrupted. Reads stay blocked for a hold time after the pin returns high. An address-stability timer puts the block into automatic sleep, and the output byte is latched while it sleeps.

The inputs are taken to be synchronous to `clk`. All delays are counted in clock cycles.

Top module: `flash_bus_ctrl`

## Requirements
- R1: `bus_mode` decodes the current pins combinationally. It shows 4 (reset) when `hwrst_n` is low. Otherwise it shows 3 (standby) when `ce_n` is high. Otherwise it shows 1 (write) when `we_n` is low and `oe_n` is high. Otherwise it shows 2 (output disable) when `oe_n` is high. Otherwise it shows 0 (read).
- R2: `dq_oe` is high in the cycle after a sample taken in read mode, once the read hold of R7 has run out. After any sample in output disable or standby mode, `dq_oe` is low.
- R3: The first sample in write mode makes `cmd_valid` high for exactly one cycle, with `cmd_addr` and `cmd_data` holding `addr` and `din` from that sample. A sample with `we_n` and `oe_n` both low produces no write.
- R4: While `hwrst_n` is low, `dq_oe` stays low, no write is issued, and `op_start` and `asel_set` are ignored.
- R5: When `hwrst_n` is low for RST_MIN consecutive samples, the pulse qualifies. It clears the busy state and autoselect, and `op_abort` pulses for one cycle if an operation was running. A shorter low pulse leaves busy and autoselect unchanged.
- R6: `ry_by` is low while an operation runs. After a qualified reset it stays low for T_REC_OP cycles if an operation was interrupted, or for T_REC_IDLE cycles otherwise. Writes sampled during recovery are ignored.
- R7: After `hwrst_n` returns high, the first T_RH high samples still leave `dq_oe` low.
- R8: The read byte is `op_status` while busy. Otherwise, while autoselect is active, it is MFR_ID when `addr[0]`=0 and DEV_ID when `addr[0]`=1. Otherwise it is `arr_rdata`. `dq_out` shows the byte chosen at the previous sample.
- R9: `op_start` sets the busy state and `op_done` clears it. Deselecting the chip with `ce_n` high does not end the busy state.
- R10: After SLEEP_T consecutive samples with an unchanged `addr`, `sleep` is high and `dq_out` holds its value. The first sample with a new address clears `sleep` and loads fresh data.
- R11: `asel_set` enters autoselect and `asel_clr` leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Block reset, active low |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| hwrst_n | input | 1 | Hardware reset pin, active low |
| addr | input | AW | Address bus |
| din | input | 8 | Write data from the bus |
| arr_rdata | input | 8 | Array byte at `addr` |
| op_status | input | 8 | Status byte of the running operation |
| op_start | input | 1 | Embedded operation start strobe |
| op_done | input | 1 | Embedded operation done strobe |
| asel_set | input | 1 | Enter autoselect |
| asel_clr | input | 1 | Leave autoselect |
| dq_out | output | 8 | Read data byte |
| dq_oe | output | 1 | Data bus drive enable |
| ry_by | output | 1 | Ready (1) / busy (0) |
| bus_mode | output | 3 | Decoded bus mode |
| sleep | output | 1 | Automatic sleep active |
| op_abort | output | 1 | Running operation terminated by reset |
| cmd_valid | output | 1 | Write pulse to the command decoder |
| cmd_addr | output | AW | Address of the write |
| cmd_data | output | 8 | Data of the write |

## Verification
Reads are tried with an address that changes every cycle, which separates live array data from latched data. They are then tried with a long stable address, while the array byte behind it changes, which shows that the sleep latch holds. Reset pulses of RST_MIN-1 and RST_MIN samples are applied both during an operation and while idle. These tell an ignored pulse from a qualified one and the long recovery from the short one. Write strobes are given with output enable high, with output enable low, and during recovery, which separates accepted writes from ignored ones. Deselecting the chip in the middle of an operation shows that busy is tied to the done strobe and not to chip enable.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  typedef enum logic [2:0] {
    BM_READ  = 3'd0,
    BM_WRITE = 3'd1,
    BM_ODIS  = 3'd2,
    BM_STBY  = 3'd3,
    BM_RST   = 3'd4
  } bus_mode_e;
endpackage

// File: rtl/fbc_mode_dec.sv
module fbc_mode_dec (
  input  logic               ce_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic               hwrst_n,
  output fbc_pkg::bus_mode_e mode
);
  import fbc_pkg::*;

  // Priority: reset pin, then chip select, then write strobe, then output enable.
  always_comb begin
    if (!hwrst_n)             mode = BM_RST;
    else if (ce_n)            mode = BM_STBY;
    else if (!we_n && oe_n)   mode = BM_WRITE;
    else if (oe_n)            mode = BM_ODIS;
    else                      mode = BM_READ;
  end
endmodule

// File: rtl/fbc_rst_ctl.sv
module fbc_rst_ctl #(
  parameter int RST_MIN    = 4,
  parameter int T_REC_OP   = 20,
  parameter int T_REC_IDLE = 6,
  parameter int T_RH       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hwrst_n,
  input  logic busy,
  output logic qual,
  output logic recovering,
  output logic read_hold
);
  localparam int T_REC_MAX = (T_REC_OP > T_REC_IDLE) ? T_REC_OP : T_REC_IDLE;
  localparam int LW = $clog2(RST_MIN + 2);
  localparam int RW = $clog2(T_REC_MAX + 2);
  localparam int HW = $clog2(T_RH + 2);

  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic [HW-1:0] hold_cnt;

  // The pulse qualifies on its RST_MIN-th consecutive low sample; the counter saturates.
  assign qual       = !hwrst_n && (low_cnt == LW'(RST_MIN - 1));
  assign recovering = (rec_cnt != '0);
  assign read_hold  = (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (hwrst_n) begin
      low_cnt <= '0;
    end else if (low_cnt != LW'(RST_MIN)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_cnt <= '0;
    end else if (qual) begin
      rec_cnt <= busy ? RW'(T_REC_OP) : RW'(T_REC_IDLE);
    end else if (rec_cnt != '0) begin
      rec_cnt <= rec_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!hwrst_n) begin
      hold_cnt <= HW'(T_RH);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fbc_sleep_tmr.sv
module fbc_sleep_tmr #(
  parameter int AW      = 16,
  parameter int SLEEP_T = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic          sleep,
  output logic          hold_data
);
  localparam int SW = $clog2(SLEEP_T + 2);

  logic [AW-1:0] addr_q;
  logic [SW-1:0] st_cnt;
  logic          addr_chg;

  assign addr_chg  = (addr != addr_q);
  assign sleep     = (st_cnt == SW'(SLEEP_T));
  assign hold_data = sleep && !addr_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      st_cnt <= '0;
    end else begin
      addr_q <= addr;
      if (addr_chg)        st_cnt <= '0;
      else if (!sleep)     st_cnt <= st_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl #(
  parameter int         AW         = 16,
  parameter int         RST_MIN    = 4,
  parameter int         T_REC_OP   = 20,
  parameter int         T_REC_IDLE = 6,
  parameter int         T_RH       = 3,
  parameter int         SLEEP_T    = 10,
  parameter logic [7:0] MFR_ID     = 8'h01,
  parameter logic [7:0] DEV_ID     = 8'hD2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hwrst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic [7:0]    arr_rdata,
  input  logic [7:0]    op_status,
  input  logic          op_start,
  input  logic          op_done,
  input  logic          asel_set,
  input  logic          asel_clr,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  output logic          ry_by,
  output logic [2:0]    bus_mode,
  output logic          sleep,
  output logic          op_abort,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data
);
  import fbc_pkg::*;

  bus_mode_e  mode;
  logic       qual, recovering, read_hold, hold_data;
  logic       busy, asel, wr_q, wr_now;
  logic [7:0] rd_src;

  fbc_mode_dec u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .hwrst_n (hwrst_n),
    .mode    (mode)
  );

  fbc_rst_ctl #(
    .RST_MIN    (RST_MIN),
    .T_REC_OP   (T_REC_OP),
    .T_REC_IDLE (T_REC_IDLE),
    .T_RH       (T_RH)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .hwrst_n    (hwrst_n),
    .busy       (busy),
    .qual       (qual),
    .recovering (recovering),
    .read_hold  (read_hold)
  );

  fbc_sleep_tmr #(
    .AW      (AW),
    .SLEEP_T (SLEEP_T)
  ) u_slp (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .sleep     (sleep),
    .hold_data (hold_data)
  );

  assign bus_mode = mode;
  assign ry_by    = !(busy || recovering);
  assign wr_now   = (mode == BM_WRITE);

  // Read source: status during an operation, then identification, then array.
  always_comb begin
    if (busy)      rd_src = op_status;
    else if (asel) rd_src = addr[0] ? DEV_ID : MFR_ID;
    else           rd_src = arr_rdata;
  end

  // Embedded operation tracking; chip enable plays no part here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     busy <= 1'b0;
    else if (qual || op_done)       busy <= 1'b0;
    else if (op_start && hwrst_n)   busy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     asel <= 1'b0;
    else if (qual || asel_clr)      asel <= 1'b0;
    else if (asel_set && hwrst_n)   asel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      op_abort <= 1'b0;
    end else begin
      if (!hold_data) dq_out <= rd_src;
      dq_oe    <= (mode == BM_READ) && !read_hold;
      op_abort <= qual && busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      wr_q      <= wr_now;
      cmd_valid <= wr_now && !wr_q && !recovering;
      if (wr_now && !wr_q && !recovering) begin
        cmd_addr <= addr;
        cmd_data <= din;
      end
    end
  end
endmodule

// File: rtl/flash_bus_ctrl_chk.sv
module flash_bus_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          hwrst_n,
  input logic [AW-1:0] addr,
  input logic [7:0]    dq_out,
  input logic          dq_oe,
  input logic          ry_by,
  input logic          sleep,
  input logic          op_abort,
  input logic          cmd_valid
);
  // R4
  hwrst_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hwrst_n |=> !dq_oe);

  // R2
  odis_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || ce_n) |=> !dq_oe);

  // R3
  wr_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(!we_n && !ce_n && oe_n && hwrst_n));

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R5
  abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |-> !ry_by);

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && $stable(addr)) |=> $stable(dq_out));
endmodule

bind flash_bus_ctrl flash_bus_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_flash_bus_ctrl.sv
module sim_flash_bus_ctrl;
  localparam int AW = 16, RST_MIN = 4, T_REC_OP = 20, T_REC_IDLE = 6, T_RH = 3, SLEEP_T = 10;
  localparam logic [7:0] MFR_ID = 8'h01, DEV_ID = 8'hD2;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, hwrst_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, key = '0, op_status = 8'h80;
  logic op_start = 0, op_done = 0, asel_set = 0, asel_clr = 0;
  logic [7:0] arr_rdata, dq_out, cmd_data;
  logic dq_oe, ry_by, sleep, op_abort, cmd_valid;
  logic [2:0] bus_mode;
  logic [AW-1:0] cmd_addr;
  int checks = 0, errors = 0;

  assign arr_rdata = addr[7:0] ^ key;

  always #5 clk = ~clk;

  flash_bus_ctrl #(.AW(AW), .RST_MIN(RST_MIN), .T_REC_OP(T_REC_OP), .T_REC_IDLE(T_REC_IDLE),
    .T_RH(T_RH), .SLEEP_T(SLEEP_T), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hwrst_n(hwrst_n),
    .addr(addr), .din(din), .arr_rdata(arr_rdata), .op_status(op_status),
    .op_start(op_start), .op_done(op_done), .asel_set(asel_set), .asel_clr(asel_clr),
    .dq_out(dq_out), .dq_oe(dq_oe), .ry_by(ry_by), .bus_mode(bus_mode), .sleep(sleep),
    .op_abort(op_abort), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_mode();
    if (!hwrst_n) return 4;
    if (ce_n) return 3;
    if (!we_n && oe_n) return 1;
    if (oe_n) return 2;
    return 0;
  endfunction

  // Behavioural reference model, advanced on every rising edge.
  int m_low = 0, m_rec = 0, m_hold = 0, m_st = 0;
  bit m_busy = 0, m_asel = 0, m_oe = 0, m_abort = 0, m_cv = 0, m_wrq = 0;
  logic [7:0] m_dq = '0, m_cd = '0;
  logic [AW-1:0] m_prev = '0, m_ca = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_low = 0; m_rec = 0; m_hold = 0; m_st = 0; m_busy = 0; m_asel = 0;
      m_oe = 0; m_abort = 0; m_cv = 0; m_wrq = 0; m_dq = '0; m_cd = '0;
      m_prev = '0; m_ca = '0;
    end else begin
      bit q, wr;
      logic [7:0] src;
      q  = !hwrst_n && (m_low == RST_MIN - 1);
      wr = (exp_mode() == 1);
      m_oe = (exp_mode() == 0) && (m_hold == 0);
      if (m_busy) src = op_status;
      else if (m_asel) src = addr[0] ? DEV_ID : MFR_ID;
      else src = arr_rdata;
      if (!((m_st == SLEEP_T) && (addr == m_prev))) m_dq = src;
      m_cv = wr && !m_wrq && (m_rec == 0);
      if (m_cv) begin m_ca = addr; m_cd = din; end
      m_wrq = wr;
      m_abort = q && m_busy;
      if (q) m_rec = m_busy ? T_REC_OP : T_REC_IDLE;
      else if (m_rec > 0) m_rec--;
      if (q || op_done) m_busy = 0;
      else if (op_start && hwrst_n) m_busy = 1;
      if (q || asel_clr) m_asel = 0;
      else if (asel_set && hwrst_n) m_asel = 1;
      m_hold = !hwrst_n ? T_RH : (m_hold > 0 ? m_hold - 1 : 0);
      if (addr != m_prev) m_st = 0;
      else if (m_st < SLEEP_T) m_st++;
      m_prev = addr;
      m_low = hwrst_n ? 0 : (m_low < RST_MIN ? m_low + 1 : m_low);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 bus_mode", bus_mode, exp_mode());
      check("R2 dq_oe", dq_oe, m_oe);
      check("R8 dq_out", dq_out, m_dq);
      check("R6 ry_by", ry_by, !(m_busy || m_rec != 0));
      check("R10 sleep", sleep, m_st == SLEEP_T);
      check("R5 op_abort", op_abort, m_abort);
      check("R3 cmd_valid", cmd_valid, m_cv);
      if (m_cv) begin
        check("R3 cmd_addr", cmd_addr, m_ca);
        check("R3 cmd_data", cmd_data, m_cd);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd_at(logic [AW-1:0] a);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a; step(1);
  endtask

  task automatic wr_strobe(logic [AW-1:0] a, logic [7:0] d);
    ce_n = 0; oe_n = 1; addr = a; din = d; we_n = 0; step(1); we_n = 1; step(1);
  endtask

  task automatic rst_pulse(int n);
    hwrst_n = 0; step(n); hwrst_n = 1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1; step(1);
    // Reset state
    check("R2 reset dq_oe", dq_oe, 0);
    check("R6 reset ry_by", ry_by, 1);
    check("R1 reset mode standby", bus_mode, 3);

    // R2 R8: array reads with a moving address
    for (int i = 0; i < 8; i++) rd_at(AW'(16'h0100 + i * 3));
    check("R8 array byte", dq_out, 8'((16'h0100 + 7 * 3) & 16'hFF));
    check("R2 read drives bus", dq_oe, 1);
    oe_n = 1; step(2);
    check("R2 output disable", dq_oe, 0);
    oe_n = 0; ce_n = 1; step(2);
    check("R2 standby tristate", dq_oe, 0);

    // R3: write strobes, one with output enable low
    wr_strobe(16'h0555, 8'hAA);
    wr_strobe(16'h02AA, 8'h55);
    ce_n = 0; oe_n = 0; we_n = 0; step(2); we_n = 1; step(1);
    check("R3 no write with oe low", cmd_valid, 0);

    // R11 R8: identification reads
    asel_set = 1; step(1); asel_set = 0;
    rd_at(16'h0000); rd_at(16'h0000);
    check("R8 R11 mfr id", dq_out, MFR_ID);
    rd_at(16'h0001); step(1);
    check("R8 R11 dev id", dq_out, DEV_ID);
    asel_clr = 1; step(1); asel_clr = 0;
    rd_at(16'h0042); step(1);
    check("R11 back to array", dq_out, 8'h42);

    // R9: operation survives deselect
    op_start = 1; step(1); op_start = 0;
    rd_at(16'h0010); step(1);
    check("R8 status while busy", dq_out, op_status);
    ce_n = 1; step(5);
    check("R9 busy across deselect", ry_by, 0);
    op_done = 1; step(1); op_done = 0; step(1);
    check("R9 done clears busy", ry_by, 1);

    // R5: short pulse during operation is ignored, long one aborts
    op_start = 1; step(1); op_start = 0;
    rst_pulse(RST_MIN - 1); step(2);
    check("R5 short pulse keeps busy", ry_by, 0);
    check("R5 short pulse no abort", op_abort, 0);
    rst_pulse(RST_MIN);
    check("R6 recovery busy", ry_by, 0);
    // R7: reads held after release
    ce_n = 0; oe_n = 0; step(T_RH);
    check("R7 read hold", dq_oe, 0);
    step(T_REC_OP);
    check("R6 recovered after op", ry_by, 1);
    check("R7 reads resume", dq_oe, 1);

    // R6: idle recovery, writes ignored during it
    asel_set = 1; step(1); asel_set = 0;
    rst_pulse(RST_MIN);
    wr_strobe(16'h0555, 8'hF0);
    check("R6 idle recovery busy", ry_by, 0);
    step(T_REC_IDLE);
    check("R6 idle recovery done", ry_by, 1);
    rd_at(16'h0000); step(1);
    check("R5 autoselect cleared", dq_out, 8'h00);

    // R4: requests ignored while reset low
    hwrst_n = 0; op_start = 1; asel_set = 1; step(1); op_start = 0; asel_set = 0;
    we_n = 0; oe_n = 1; step(1); we_n = 1; oe_n = 0; hwrst_n = 1; step(T_RH + 2);
    check("R4 start ignored in reset", ry_by, 1);

    // R10: sleep latches data
    rd_at(16'h0005); step(SLEEP_T + 2);
    check("R10 sleeping", sleep, 1);
    key = 8'hFF; step(2);
    check("R10 latched byte", dq_out, 8'h05);
    rd_at(16'h0006);
    check("R10 wake new data", dq_out, 8'hF9);
    check("R10 sleep cleared", sleep, 0);
    key = 8'h00; step(3);

    finish_run();
  end
endmodule